// File: doc/BRIEF.md
# Dual-Width Condition Evaluator

This block turns a 64-bit general-purpose register value into condition flags and branch decisions, so a core needs no width-specific flag-setting operations. From one value it forms a full-width flag set and a low-word flag set. The low-word set takes its negative, zero, carry and overflow indications from fixed bit positions of the 64-bit result. A branch chooses which width to test and which condition to apply.

Two sources feed the branch. In register-test mode the branch reads its flags directly from the value presented with it. In flag-register mode it reads a small stored flag register. A flag-setting strobe writes the full-width and low-word sets of that register together in one cycle. The full-width carry and overflow cannot be recovered from the result bits, so the producing unit supplies them alongside the strobe. Flag derivation and branch evaluation are combinational. Only the flag register is clocked.

Top module: `dw_cond_unit`

## Requirements
- R1: Full-width flags derived from a value are packed {N,Z,C,V} in bits [3:0], with N at bit 3. N is bit 63 and Z is 1 only when all 64 bits are zero. C and V are 0 because the value alone cannot supply them.
- R2: The low-word Z flag is 1 exactly when bits 31..0 are all zero, whatever bits 63..32 hold.
- R3: The low-word N flag equals bit 31, C equals bit 32, and V is bit 32 XOR bit 31.
- R4: Condition codes: 0 eq (Z), 1 ne (!Z), 2 lt (N!=V), 3 ge (N==V), 4 gt (!Z and N==V), 5 le (Z or N!=V), 6 carry set, 7 carry clear, 8 overflow set, 9 overflow clear, 10 always.
- R5: Width select 0 makes the branch test the full-width flags. Width select 1 makes it test the low-word flags.
- R6: With the source select at 0 (register test), the branch uses flags derived from the branch value, and the stored flag register has no effect on the outcome.
- R7: With the source select at 1 (flag register), the branch uses the stored flags, and the branch value has no effect on the outcome.
- R8: A flag-setting strobe, sampled at a rising clock edge, writes both stored sets at that edge. The low-word set is derived from the set value as in R2 and R3. The full-width set takes N and Z from the set value, and C and V from the carry and overflow inputs.
- R9: Without a strobe the stored flags hold their values. A synchronous active-high reset clears both stored sets to zero.
- R10: Code 11 and the unused codes 12..15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Flag-setting strobe |
| set_value | input | 64 | Result whose flags are stored |
| set_carry | input | 1 | Full-width carry from the producing unit |
| set_ovf | input | 1 | Full-width overflow from the producing unit |
| br_use_reg | input | 1 | 0: test the branch value, 1: test the stored flags |
| br_wide_sel | input | 1 | 0: full-width flags, 1: low-word flags |
| br_cond | input | 4 | Condition code |
| br_value | input | 64 | Register value tested in register-test mode |
| val_flags64 | output | 4 | Full-width {N,Z,C,V} of br_value |
| val_flags32 | output | 4 | Low-word {N,Z,C,V} of br_value |
| reg_flags64 | output | 4 | Stored full-width flags |
| reg_flags32 | output | 4 | Stored low-word flags |
| br_taken | output | 1 | Branch outcome |

## Verification
Values are drawn from several patterns, each aimed at one way the two widths can disagree:
- all zero;
- zero low word under a non-zero upper half, which separates the two Z flags;
- bit 32 set with bit 31 clear and the reverse, which exercises low-word carry against overflow;
- sign bit set with a clear low word;
- fully random.

Each cycle picks the source, width and condition code at random, including the never-taken codes. Changes to the branch value while the stored flags are tested, and to the stored flags while the branch value is tested, show that the unselected source is ignored. Strobes are spaced irregularly, so the model also checks that the stored flags hold between strobes.

// File: rtl/dw_cond_pkg.sv
package dw_cond_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_LT = 4'd2,
        CC_GE = 4'd3,
        CC_GT = 4'd4,
        CC_LE = 4'd5,
        CC_CS = 4'd6,
        CC_CC = 4'd7,
        CC_VS = 4'd8,
        CC_VC = 4'd9,
        CC_AL = 4'd10,
        CC_NV = 4'd11
    } cond_e;

    function automatic logic cond_true(flags_t f, logic [3:0] code);
        logic signed_lt;
        signed_lt = f.n ^ f.v;
        case (code)
            CC_EQ:   return f.z;
            CC_NE:   return !f.z;
            CC_LT:   return signed_lt;
            CC_GE:   return !signed_lt;
            CC_GT:   return !f.z && !signed_lt;
            CC_LE:   return f.z || signed_lt;
            CC_CS:   return f.c;
            CC_CC:   return !f.c;
            CC_VS:   return f.v;
            CC_VC:   return !f.v;
            CC_AL:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dw_flag_derive.sv
module dw_flag_derive
    import dw_cond_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NW   = 32
) (
    input  logic [XLEN-1:0] val,
    output flags_t          wide,
    output flags_t          narrow
);
    localparam int NMSB = NW - 1;

    always_comb begin
        wide.n   = val[XLEN-1];
        wide.z   = (val == '0);
        wide.c   = 1'b0;
        wide.v   = 1'b0;
        narrow.n = val[NMSB];
        narrow.z = (val[NMSB:0] == '0);
        narrow.c = val[NW];
        narrow.v = val[NW] ^ val[NMSB];
    end
endmodule

// File: rtl/dw_flag_reg.sv
module dw_flag_reg
    import dw_cond_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_valid,
    input  flags_t d_wide,
    input  flags_t d_narrow,
    output flags_t q_wide,
    output flags_t q_narrow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_wide   <= '0;
            q_narrow <= '0;
        end else if (set_valid) begin
            q_wide   <= d_wide;
            q_narrow <= d_narrow;
        end
    end

    // R8
    both_sets_written_chk: assert property (@(posedge clk) disable iff (rst)
        set_valid |=> (q_wide == $past(d_wide)) && (q_narrow == $past(d_narrow)));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !set_valid |=> $stable(q_wide) && $stable(q_narrow));
endmodule

// File: rtl/dw_cond_eval.sv
module dw_cond_eval
    import dw_cond_pkg::*;
(
    input  flags_t     f_wide,
    input  flags_t     f_narrow,
    input  logic       wide_sel,
    input  logic [3:0] cond,
    output logic       taken
);
    flags_t f_sel;

    always_comb begin
        f_sel = wide_sel ? f_narrow : f_wide;
        taken = cond_true(f_sel, cond);
    end
endmodule

// File: rtl/dw_cond_unit.sv
module dw_cond_unit
    import dw_cond_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_valid,
    input  logic [XLEN-1:0] set_value,
    input  logic            set_carry,
    input  logic            set_ovf,
    input  logic            br_use_reg,
    input  logic            br_wide_sel,
    input  logic [3:0]      br_cond,
    input  logic [XLEN-1:0] br_value,
    output logic [3:0]      val_flags64,
    output logic [3:0]      val_flags32,
    output logic [3:0]      reg_flags64,
    output logic [3:0]      reg_flags32,
    output logic            br_taken
);
    flags_t bv_wide, bv_narrow;
    flags_t sv_wide, sv_narrow;
    flags_t st_wide, st_narrow;
    flags_t d_wide;
    flags_t src_wide, src_narrow;

    dw_flag_derive #(.XLEN(XLEN), .NW(NW)) u_br_derive (
        .val(br_value), .wide(bv_wide), .narrow(bv_narrow));

    dw_flag_derive #(.XLEN(XLEN), .NW(NW)) u_set_derive (
        .val(set_value), .wide(sv_wide), .narrow(sv_narrow));

    always_comb begin
        d_wide   = sv_wide;
        d_wide.c = set_carry;
        d_wide.v = set_ovf;
    end

    dw_flag_reg u_freg (
        .clk(clk), .rst(rst), .set_valid(set_valid),
        .d_wide(d_wide), .d_narrow(sv_narrow),
        .q_wide(st_wide), .q_narrow(st_narrow));

    always_comb begin
        src_wide   = br_use_reg ? st_wide   : bv_wide;
        src_narrow = br_use_reg ? st_narrow : bv_narrow;
    end

    dw_cond_eval u_eval (
        .f_wide(src_wide), .f_narrow(src_narrow), .wide_sel(br_wide_sel),
        .cond(br_cond), .taken(br_taken));

    assign val_flags64 = bv_wide;
    assign val_flags32 = bv_narrow;
    assign reg_flags64 = st_wide;
    assign reg_flags32 = st_narrow;

    // R5, R6
    narrow_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (!br_use_reg && br_wide_sel && br_cond == 4'd0) |->
            (br_taken == (br_value[NW-1:0] == '0)));

    // R6
    wide_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (!br_use_reg && !br_wide_sel && br_cond == 4'd0) |->
            (br_taken == (br_value == '0)));

    // R10
    never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_cond >= 4'd11) |-> !br_taken);

    // R4
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_cond == 4'd10) |-> br_taken);
endmodule

// File: tb/dw_cond_unit_test.sv
module dw_cond_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        set_valid, set_carry, set_ovf;
    logic [63:0] set_value, br_value;
    logic        br_use_reg, br_wide_sel;
    logic [3:0]  br_cond;
    logic [3:0]  val_flags64, val_flags32, reg_flags64, reg_flags32;
    logic        br_taken;

    int checks = 0;
    int errors = 0;
    logic [3:0] m64, m32;

    always #5 clk = ~clk;

    dw_cond_unit uut (
        .clk(clk), .rst(rst), .set_valid(set_valid), .set_value(set_value),
        .set_carry(set_carry), .set_ovf(set_ovf), .br_use_reg(br_use_reg),
        .br_wide_sel(br_wide_sel), .br_cond(br_cond), .br_value(br_value),
        .val_flags64(val_flags64), .val_flags32(val_flags32),
        .reg_flags64(reg_flags64), .reg_flags32(reg_flags32), .br_taken(br_taken));

    function automatic logic [3:0] ref64(input logic [63:0] x);
        int nz;
        nz = (x == 64'd0) ? 1 : 0;
        return {x[63], nz[0], 2'b00};
    endfunction

    function automatic logic [3:0] ref32(input logic [63:0] x);
        logic lz;
        lz = (x[31:0] == 32'd0);
        return {x[31], lz, x[32], (x[32] != x[31])};
    endfunction

    function automatic logic ref_taken(input logic [3:0] f, input logic [3:0] c);
        int n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        if (c == 0)  return z == 1;
        if (c == 1)  return z == 0;
        if (c == 2)  return n != v;
        if (c == 3)  return n == v;
        if (c == 4)  return (z == 0) && (n == v);
        if (c == 5)  return (z == 1) || (n != v);
        if (c == 6)  return cy == 1;
        if (c == 7)  return cy == 0;
        if (c == 8)  return v == 1;
        if (c == 9)  return v == 0;
        if (c == 10) return 1'b1;
        return 1'b0; // R10
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pick_value();
        logic [63:0] r;
        r = {$urandom, $urandom};
        case ($urandom % 6)
            0: return 64'd0;
            1: return {r[63:32] | 32'h1, 32'd0};
            2: return {r[63:33], 1'b1, 1'b0, r[30:0]};
            3: return {r[63:33], 1'b0, 1'b1, r[30:0]};
            4: return {1'b1, r[62:32], 32'd0};
            default: return r;
        endcase
    endfunction

    task automatic compare_all(input string tag);
        logic [3:0] f;
        chk("R1", {60'd0, val_flags64}, {60'd0, ref64(br_value)});
        chk("R2,R3", {60'd0, val_flags32}, {60'd0, ref32(br_value)});
        chk("R8,R9 wide", {60'd0, reg_flags64}, {60'd0, m64});
        chk("R8,R9 narrow", {60'd0, reg_flags32}, {60'd0, m32});
        if (br_use_reg) f = br_wide_sel ? m32 : m64;
        else            f = br_wide_sel ? ref32(br_value) : ref64(br_value);
        chk(tag, {63'd0, br_taken}, {63'd0, ref_taken(f, br_cond)});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (rst) begin m64 = 4'd0; m32 = 4'd0; end
        else if (set_valid) begin
            m64 = {ref64(set_value)[3:2], set_carry, set_ovf};
            m32 = ref32(set_value);
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; set_valid = 1'b0; set_value = '0; set_carry = 1'b0; set_ovf = 1'b0;
        br_use_reg = 1'b0; br_wide_sel = 1'b0; br_cond = 4'd0; br_value = '0;
        m64 = 4'hx; m32 = 4'hx;
        step(); step();
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R9 reset wide", {60'd0, reg_flags64}, 64'd0);
        chk("R9 reset narrow", {60'd0, reg_flags32}, 64'd0);

        // R2: zero low word under non-zero upper half
        @(negedge clk);
        br_value = 64'hDEAD_0000_0000_0000; br_wide_sel = 1'b1; br_cond = 4'd0;
        #1; compare_all("R2,R5 eq narrow");
        chk("R2 narrow eq", {63'd0, br_taken}, 64'd1);
        br_wide_sel = 1'b0;
        #1; chk("R5 wide eq", {63'd0, br_taken}, 64'd0);

        // R8: write, then R7: value ignored in flag-register mode
        set_valid = 1'b1; set_value = 64'h0000_0001_0000_0000; set_carry = 1'b1; set_ovf = 1'b0;
        step();
        @(negedge clk); set_valid = 1'b0;
        br_use_reg = 1'b1; br_wide_sel = 1'b1; br_cond = 4'd6;
        br_value = 64'd0;
        #1; compare_all("R7,R8 cs narrow");
        br_value = 64'hFFFF_FFFF_FFFF_FFFF;
        #1; chk("R7 value ignored", {63'd0, br_taken}, 64'd1);
        br_wide_sel = 1'b0; br_cond = 4'd0;
        #1; chk("R8 wide z stored", {63'd0, br_taken}, 64'd0);

        for (int i = 0; i < 3000; i++) begin
            step();
            @(negedge clk);
            set_valid   = ($urandom % 3) == 0;
            set_value   = pick_value();
            set_carry   = $urandom;
            set_ovf     = $urandom;
            br_use_reg  = $urandom;
            br_wide_sel = $urandom;
            br_cond     = $urandom;
            br_value    = pick_value();
            rst         = ($urandom % 200) == 0;
            #1;
            if (br_cond >= 4'd11)  compare_all("R10");
            else if (br_use_reg)   compare_all("R4,R5,R7");
            else                   compare_all("R4,R5,R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule